// File: doc/BRIEF.md
# Pin Configuration Register Bank

This block stores the static setup of several 32-pin I/O ports and presents it to the pad ring. Software reaches it over a small word-oriented read/write bus. Each port has its own address window. Inside that window sit four registers with one bit per pin: direction, GPIO ownership, alternate-function choice and pull-up. Three controls carry two bits per pin: output configuration and input configurations A and B. Each of these spans two consecutive words, one for the low half of the port's pins and one for the high half.

Every stored field is also driven continuously onto flat per-pin output vectors, so the pad logic never has to go through the bus. Reads return data one cycle after the request. Holes in the map read as zero and cannot be written.

Top module: `pincfg_bank`

## Requirements
- R1: The port number is taken from address bits [ADDR_W-1:8], so each port owns a 0x100-byte window. Offsets inside a window are byte offsets whose bits [7:2] select a word.
- R2: The one-bit registers sit at these window offsets: 0x00 direction, 0x20 GPIO ownership, 0x38 function select, 0x40 pull-up. Bit n of each controls pin n of that port.
- R3: The two-bit controls occupy these pairs of offsets: output configuration at 0x04 and 0x08, input configuration A at 0x0C and 0x10, input configuration B at 0x14 and 0x18. Pins 0–15 sit in the lower word of each pair and pins 16–31 in the upper word. Pin n uses bits [2(n mod 16)+1 : 2(n mod 16)] of its word.
- R4: When bus_en and bus_we are both high on a clock edge and the target is mapped, the full 32-bit bus_wdata is stored in the addressed register.
- R5: On the cycle after an edge with bus_en high and bus_we low, bus_rdata holds the addressed word, or zero if the target is unmapped. On the cycle after any other edge, bus_rdata is zero.
- R6: A target is unmapped if its offset is not one of the ten listed, or if address bits [1:0] are not zero. An unmapped target reads as zero, and a write to it changes no register.
- R7: A port number of NUM_PORTS or more is unmapped. It reads as zero, and a write to it changes no register.
- R8: A synchronous reset (rst high on an edge) clears every register, every pin output and bus_rdata to zero, and any write in that cycle is dropped.
- R9: Pin n of port p drives one-bit outputs at index 32p+n. It drives two-bit outputs at bits [2(32p+n)+1 : 2(32p+n)].
- R10: A write changes only the one register it addresses. All other registers, in the same port and in other ports, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| pin_dir | output | NUM_PORTS*32 | Direction per pin |
| pin_gpio | output | NUM_PORTS*32 | GPIO ownership per pin |
| pin_func | output | NUM_PORTS*32 | Alternate-function select per pin |
| pin_pull | output | NUM_PORTS*32 | Pull-up enable per pin |
| pin_ocfg | output | NUM_PORTS*64 | Output configuration, two bits per pin |
| pin_icfga | output | NUM_PORTS*64 | Input configuration A, two bits per pin |
| pin_icfgb | output | NUM_PORTS*64 | Input configuration B, two bits per pin |

## Verification
The bench goes after the split of the two-bit controls. A decoder that swapped the lower and upper words would drive pin 17's field with data meant for pin 1. The bench also writes to the holes at 0x1C, 0x24 and 0x3C, to misaligned addresses and to port numbers beyond NUM_PORTS: a loose decoder would alias these onto real registers, and the flat outputs or a later readback would change. It issues writes during reset and reads right after writes. A design that let writes through during reset, or that returned stale or non-zero idle read data, would show a bus_rdata mismatch on the following cycle.

// File: rtl/pincfg_pkg.sv
package pincfg_pkg;

    localparam int WORD_W   = 32;
    localparam int PORT_PINS = 32;
    localparam int WIN_LSB  = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_OCFG_LO,
        SEL_OCFG_HI,
        SEL_INA_LO,
        SEL_INA_HI,
        SEL_INB_LO,
        SEL_INB_HI,
        SEL_GPIO,
        SEL_FUNC,
        SEL_PULL
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] dir;
        logic [WORD_W-1:0] gpio;
        logic [WORD_W-1:0] func;
        logic [WORD_W-1:0] pull;
        logic [WORD_W-1:0] ocfg_lo;
        logic [WORD_W-1:0] ocfg_hi;
        logic [WORD_W-1:0] ina_lo;
        logic [WORD_W-1:0] ina_hi;
        logic [WORD_W-1:0] inb_lo;
        logic [WORD_W-1:0] inb_hi;
    } port_regs_t;

    // word index = byte offset / 4 inside a port window
    function automatic reg_sel_e word_to_sel(input logic [5:0] widx);
        reg_sel_e s;
        case (widx)
            6'd0:    s = SEL_DIR;
            6'd1:    s = SEL_OCFG_LO;
            6'd2:    s = SEL_OCFG_HI;
            6'd3:    s = SEL_INA_LO;
            6'd4:    s = SEL_INA_HI;
            6'd5:    s = SEL_INB_LO;
            6'd6:    s = SEL_INB_HI;
            6'd8:    s = SEL_GPIO;
            6'd14:   s = SEL_FUNC;
            6'd16:   s = SEL_PULL;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pincfg_decode.sv
module pincfg_decode
    import pincfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 12,
    localparam int PIDX_W   = ADDR_W - WIN_LSB
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_PORTS-1:0] port_wr,
    output reg_sel_e          sel,
    output logic [PIDX_W-1:0] port_idx,
    output logic              rd_hit
);

    logic aligned;
    logic in_range;
    logic hit;

    always_comb begin
        port_idx = bus_addr[ADDR_W-1:WIN_LSB];
        aligned  = (bus_addr[1:0] == 2'b00);
        in_range = (int'(port_idx) < NUM_PORTS);
        sel      = word_to_sel(bus_addr[WIN_LSB-1:2]);
        hit      = aligned && in_range && (sel != SEL_NONE);
        rd_hit   = bus_en && !bus_we && hit;
        port_wr  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_en && bus_we && hit && (port_idx == PIDX_W'(p)))
                port_wr[p] = 1'b1;
        end
    end

endmodule

// File: rtl/pincfg_port.sv
module pincfg_port
    import pincfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  reg_sel_e           sel,
    input  logic [WORD_W-1:0]  wdata,
    output logic [WORD_W-1:0]  rd_word,
    output logic [PORT_PINS-1:0]   dir_o,
    output logic [PORT_PINS-1:0]   gpio_o,
    output logic [PORT_PINS-1:0]   func_o,
    output logic [PORT_PINS-1:0]   pull_o,
    output logic [2*PORT_PINS-1:0] ocfg_o,
    output logic [2*PORT_PINS-1:0] ina_o,
    output logic [2*PORT_PINS-1:0] inb_o
);

    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (rst) begin
            regs_d = '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DIR:     regs_d.dir     = wdata;
                SEL_OCFG_LO: regs_d.ocfg_lo = wdata;
                SEL_OCFG_HI: regs_d.ocfg_hi = wdata;
                SEL_INA_LO:  regs_d.ina_lo  = wdata;
                SEL_INA_HI:  regs_d.ina_hi  = wdata;
                SEL_INB_LO:  regs_d.inb_lo  = wdata;
                SEL_INB_HI:  regs_d.inb_hi  = wdata;
                SEL_GPIO:    regs_d.gpio    = wdata;
                SEL_FUNC:    regs_d.func    = wdata;
                SEL_PULL:    regs_d.pull    = wdata;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_DIR:     rd_word = regs_q.dir;
            SEL_OCFG_LO: rd_word = regs_q.ocfg_lo;
            SEL_OCFG_HI: rd_word = regs_q.ocfg_hi;
            SEL_INA_LO:  rd_word = regs_q.ina_lo;
            SEL_INA_HI:  rd_word = regs_q.ina_hi;
            SEL_INB_LO:  rd_word = regs_q.inb_lo;
            SEL_INB_HI:  rd_word = regs_q.inb_hi;
            SEL_GPIO:    rd_word = regs_q.gpio;
            SEL_FUNC:    rd_word = regs_q.func;
            SEL_PULL:    rd_word = regs_q.pull;
            default:     rd_word = '0;
        endcase
    end

    // low word carries pins 0-15, high word pins 16-31; two bits per pin
    assign dir_o  = regs_q.dir;
    assign gpio_o = regs_q.gpio;
    assign func_o = regs_q.func;
    assign pull_o = regs_q.pull;
    assign ocfg_o = {regs_q.ocfg_hi, regs_q.ocfg_lo};
    assign ina_o  = {regs_q.ina_hi,  regs_q.ina_lo};
    assign inb_o  = {regs_q.inb_hi,  regs_q.inb_lo};

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (regs_q == '0));

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_DIR) |=> (dir_o == $past(wdata)));

    // R3
    ocfg_high_half_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_OCFG_HI) |=> (ocfg_o[2*PORT_PINS-1:PORT_PINS] == $past(wdata)));

endmodule

// File: rtl/pincfg_bank.sv
module pincfg_bank
    import pincfg_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 12,
    localparam int PIDX_W   = ADDR_W - WIN_LSB,
    localparam int NPINS    = NUM_PORTS * PORT_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [NPINS-1:0]   pin_dir,
    output logic [NPINS-1:0]   pin_gpio,
    output logic [NPINS-1:0]   pin_func,
    output logic [NPINS-1:0]   pin_pull,
    output logic [2*NPINS-1:0] pin_ocfg,
    output logic [2*NPINS-1:0] pin_icfga,
    output logic [2*NPINS-1:0] pin_icfgb
);

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    logic [NUM_PORTS-1:0] port_wr;
    reg_sel_e             sel;
    logic [PIDX_W-1:0]    port_idx;
    logic                 rd_hit;
    logic [WORD_W-1:0]    port_word [NUM_PORTS];
    logic [WORD_W-1:0]    sel_word;
    rd_state_t            rd_d, rd_q;

    pincfg_decode #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .port_wr  (port_wr),
        .sel      (sel),
        .port_idx (port_idx),
        .rd_hit   (rd_hit)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pincfg_port u_port (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (port_wr[p]),
            .sel     (sel),
            .wdata   (bus_wdata),
            .rd_word (port_word[p]),
            .dir_o   (pin_dir  [p*PORT_PINS +: PORT_PINS]),
            .gpio_o  (pin_gpio [p*PORT_PINS +: PORT_PINS]),
            .func_o  (pin_func [p*PORT_PINS +: PORT_PINS]),
            .pull_o  (pin_pull [p*PORT_PINS +: PORT_PINS]),
            .ocfg_o  (pin_ocfg [2*p*PORT_PINS +: 2*PORT_PINS]),
            .ina_o   (pin_icfga[2*p*PORT_PINS +: 2*PORT_PINS]),
            .inb_o   (pin_icfgb[2*p*PORT_PINS +: 2*PORT_PINS])
        );
    end

    always_comb begin
        sel_word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (port_idx == PIDX_W'(p))
                sel_word = port_word[p];
        end
    end

    always_comb begin
        rd_d.rdata = '0;
        if (!rst && rd_hit)
            rd_d.rdata = sel_word;
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    // R5
    idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(bus_en && !bus_we)) |-> (bus_rdata == '0));

    // R10
    single_port_write_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_wr));

    // R7
    far_port_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr[ADDR_W-1:WIN_LSB]) >= NUM_PORTS) |-> (port_wr == '0));

    // R6
    misaligned_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (port_wr == '0));

endmodule

// File: tb/pincfg_bank_test.sv
module pincfg_bank_test;

    localparam int PERIOD = 10;
    localparam int NP     = 4;
    localparam int AW     = 12;
    localparam int NPIN   = NP * 32;

    logic clk = 1'b0;
    logic rst;
    logic bus_en, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [NPIN-1:0]   pin_dir, pin_gpio, pin_func, pin_pull;
    logic [2*NPIN-1:0] pin_ocfg, pin_icfga, pin_icfgb;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] mdl [NP][64];

    always #(PERIOD/2) clk = ~clk;

    pincfg_bank #(.NUM_PORTS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_dir(pin_dir), .pin_gpio(pin_gpio), .pin_func(pin_func),
        .pin_pull(pin_pull), .pin_ocfg(pin_ocfg), .pin_icfga(pin_icfga),
        .pin_icfgb(pin_icfgb)
    );

    function automatic bit is_reg(input int w);
        return (w inside {0, 1, 2, 3, 4, 5, 6, 8, 14, 16});
    endfunction

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_model();
        for (int p = 0; p < NP; p++)
            for (int w = 0; w < 64; w++)
                mdl[p][w] = '0;
    endtask

    task automatic compare_pins();
        logic [NPIN-1:0] e1 [4];
        logic [2*NPIN-1:0] e2 [3];
        for (int p = 0; p < NP; p++) begin
            e1[0][p*32 +: 32] = mdl[p][0];
            e1[1][p*32 +: 32] = mdl[p][8];
            e1[2][p*32 +: 32] = mdl[p][14];
            e1[3][p*32 +: 32] = mdl[p][16];
            e2[0][p*64 +: 64] = {mdl[p][2], mdl[p][1]};
            e2[1][p*64 +: 64] = {mdl[p][4], mdl[p][3]};
            e2[2][p*64 +: 64] = {mdl[p][6], mdl[p][5]};
        end
        check("R2 R9 dir",   256'(pin_dir),   256'(e1[0]));
        check("R2 R9 gpio",  256'(pin_gpio),  256'(e1[1]));
        check("R2 R9 func",  256'(pin_func),  256'(e1[2]));
        check("R2 R9 pull",  256'(pin_pull),  256'(e1[3]));
        check("R3 R9 ocfg",  256'(pin_ocfg),  256'(e2[0]));
        check("R3 R9 icfga", 256'(pin_icfga), 256'(e2[1]));
        check("R3 R9 icfgb", 256'(pin_icfgb), 256'(e2[2]));
    endtask

    // called at a negedge; returns at the next negedge after comparing
    task automatic step(input logic en, input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] exp_rd;
        int p;
        int w;
        bit hit;
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        p = int'(a[AW-1:8]);
        w = int'(a[7:2]);
        hit = (p < NP) && (a[1:0] == 2'b00) && is_reg(w);
        exp_rd = '0;
        if (en && !we && hit) exp_rd = mdl[p][w];
        if (en && we && hit)  mdl[p][w] = d;
        @(negedge clk);
        check("R5 R6 R7 rdata", 256'(bus_rdata), 256'(exp_rd));
        compare_pins();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'h000; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        @(negedge clk);
        clear_model();
        // R8: write during reset dropped, everything zero
        check("R8 rdata", 256'(bus_rdata), 256'(0));
        compare_pins();
        rst = 1'b0;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    initial begin
        #(PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] offs [12];
        rst = 1'b1; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        clear_model();
        @(negedge clk);
        do_reset();

        // R2 R9: direction of port 1, pins 0 and 31
        step(1, 1, 12'h100, 32'h8000_0001);
        check("R9 pin32", 256'(pin_dir[32]), 256'(1));
        check("R9 pin63", 256'(pin_dir[63]), 256'(1));
        // R3: upper word of output config, port 2, pin 17 field = 3
        step(1, 1, 12'h208, 32'h0000_000C);
        check("R3 pin17 field", 256'(pin_ocfg[2*(64+17) +: 2]), 256'(2'b11));
        check("R3 pin1 field",  256'(pin_ocfg[2*(64+1) +: 2]),  256'(2'b00));
        // R4 R5: readback, plus idle cycle gives zero
        step(1, 0, 12'h208, '0);
        step(0, 0, 12'h208, '0);
        // R6: holes and misaligned targets
        step(1, 1, 12'h01C, 32'hDEAD_BEEF);
        step(1, 1, 12'h024, 32'h1234_5678);
        step(1, 1, 12'h03C, 32'hA5A5_A5A5);
        step(1, 1, 12'h101, 32'hFFFF_FFFF);
        step(1, 0, 12'h01C, '0);
        step(1, 0, 12'h102, '0);
        // R7: beyond the last port
        step(1, 1, 12'h500, 32'hFFFF_FFFF);
        step(1, 1, 12'hF40, 32'hFFFF_FFFF);
        step(1, 0, 12'h500, '0);
        // R1 R10: same offsets in every port, each port distinct
        for (int p = 0; p < NP; p++) step(1, 1, AW'(p * 256 + 'h40), 32'h1111_0000 + p);
        for (int p = 0; p < NP; p++) step(1, 0, AW'(p * 256 + 'h40), '0);

        offs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20, 8'h38, 8'h40, 8'h1C, 8'h3C};
        for (int i = 0; i < 4000; i++) begin
            int pr;
            logic [AW-1:0] a;
            pr = ($urandom_range(0, 7) == 0) ? int'($urandom_range(4, 15)) : int'($urandom_range(0, 3));
            a = AW'(pr * 256) | AW'(offs[$urandom_range(0, 11)]);
            if ($urandom_range(0, 15) == 0) a[1:0] = 2'($urandom_range(1, 3));
            step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), a, $urandom);
            if (i == 2000) do_reset();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule